// File: doc/BRIEF.md
# Bit Manipulation and Carry Unit

This block does the bit-level work of an 8-bit processor core. Each cycle with a valid operation it receives an operation class, the opcode byte, the 16-bit instruction operand, the byte already fetched from memory, the accumulator and the current carry flag. One clock later it presents a registered result: the byte to write back with its write strobe, the next carry with an update strobe, zero/negative flag values with their own update strobe, a branch decision for the bit-test branches, and the byte address taken from the operand.

The operations are single-bit set or clear, branch on a bit being set or clear, carry combined with a memory bit (OR, AND and XOR, with inverted-bit variants of OR and AND), load carry from a bit, store carry into a bit, toggle a bit, and the accumulator-masked test-and-set and test-and-clear. The short forms take their bit number from the opcode; the long forms take it from the top of the operand. Fetching, address arithmetic and bus sequencing belong to the surrounding core.

Top module: `bitcarry_unit`

## Requirements
- R1: While reset is asserted (rst_n low) and in the first cycle after it, every output is zero.
- R2: Outputs appear exactly one clock after the inputs are presented with in_valid high; a cycle with in_valid low gives all outputs zero in the following cycle.
- R3: For class 1 (single-bit set/clear) the bit number is opcode bits [7:5]; opcode bit 4 low sets that bit, high clears it; wr_en is 1 and the carry and Z/N strobes stay 0.
- R4: For class 2 (bit-test branch) the bit number is opcode bits [7:5]; br_taken is 1 when that memory bit is 1 with opcode bit 4 low, or 0 with opcode bit 4 high; no write and no flag strobe.
- R5: addr_o always equals operand bits [12:0]; for classes 3 to 12 the bit number is operand bits [15:13].
- R6: Classes 3 (OR), 4 (OR with inverted bit), 5 (AND), 6 (AND with inverted bit) and 7 (XOR) give carry_o as carry_i combined with the memory bit, with carry_upd 1, wr_en 0 and wr_data equal to the memory byte.
- R7: Class 8 loads carry_o from the memory bit (carry_upd 1, no write); class 9 writes the memory byte with only the addressed bit replaced by carry_i, with carry_upd 0.
- R8: Class 10 writes the memory byte with the addressed bit inverted and raises no flag strobe.
- R9: Class 11 writes memory OR accumulator and class 12 writes memory AND NOT accumulator; both raise zn_upd with z_o set when the 8-bit value acc minus memory is zero and n_o equal to its bit 7; carry_upd stays 0.
- R10: When a flag strobe is 0, carry_o equals carry_i and z_o, n_o are 0; classes 0, 13, 14 and 15 only pass the memory byte and carry through, with no write, no branch and no flag strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation class (0 to 12 used) |
| opc_i | input | 8 | Opcode byte, source of short-form bit number and polarity |
| operand_i | input | 16 | Instruction operand: byte address and long-form bit number |
| mem_i | input | 8 | Byte read from memory |
| acc_i | input | 8 | Accumulator |
| carry_i | input | 1 | Current carry flag |
| out_valid | output | 1 | Result present |
| wr_en | output | 1 | Write wr_data back to memory |
| wr_data | output | 8 | Byte to write back |
| addr_o | output | 13 | Byte address from the operand |
| carry_upd | output | 1 | Carry flag takes carry_o |
| carry_o | output | 1 | Next carry value |
| zn_upd | output | 1 | Z and N take z_o and n_o |
| z_o | output | 1 | Zero flag value |
| n_o | output | 1 | Negative flag value |
| br_taken | output | 1 | Bit-test branch is taken |

## Verification
Every class runs at all eight bit positions with random memory, accumulator and carry, so a design that pulled the bit number from the wrong field (opcode versus operand) or swapped the polarity bit would hit the wrong bit or branch the wrong way at some position. Directed cases put the accumulator equal to memory and one above it for the test forms, catching a compare taken in the wrong direction or a carry strobe raised by them. Store-carry runs with the target bit both matching and opposite carry, exposing a store that merges rather than replaces, and idle cycles and unused classes show any stray write or flag strobe.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

    typedef enum logic [3:0] {
        OP_NONE  = 4'd0,
        OP_BITSC = 4'd1,
        OP_BITBR = 4'd2,
        OP_COR   = 4'd3,
        OP_CORN  = 4'd4,
        OP_CAND  = 4'd5,
        OP_CANDN = 4'd6,
        OP_CXOR  = 4'd7,
        OP_CLD   = 4'd8,
        OP_CST   = 4'd9,
        OP_TGL   = 4'd10,
        OP_TSET  = 4'd11,
        OP_TCLR  = 4'd12
    } bcu_op_e;

endpackage

// File: rtl/bcu_decode.sv
module bcu_decode #(
    parameter int DATA_W = 8,
    parameter int OPC_W  = 8,
    parameter int OPER_W = 16,
    parameter int ADDR_W = 13,
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  bcu_pkg::bcu_op_e    op,
    input  logic [OPC_W-1:0]    opc,
    input  logic [OPER_W-1:0]   operand,
    output logic [DATA_W-1:0]   mask,
    output logic                pol_clear,
    output logic [ADDR_W-1:0]   addr
);
    import bcu_pkg::*;

    logic              short_form;
    logic [BIT_W-1:0]  bit_idx;

    always_comb begin
        short_form = (op == OP_BITSC) || (op == OP_BITBR);
        bit_idx    = short_form ? opc[OPC_W-1 -: BIT_W]
                                : operand[OPER_W-1 -: BIT_W];
        mask       = DATA_W'(1) << bit_idx;
        pol_clear  = opc[OPC_W-1-BIT_W];
        addr       = operand[ADDR_W-1:0];
    end

endmodule

// File: rtl/bcu_bitops.sv
module bcu_bitops #(
    parameter int DATA_W = 8
) (
    input  bcu_pkg::bcu_op_e    op,
    input  logic [DATA_W-1:0]   mem,
    input  logic [DATA_W-1:0]   acc,
    input  logic [DATA_W-1:0]   mask,
    input  logic                pol_clear,
    input  logic                carry,
    output logic [DATA_W-1:0]   wdata,
    output logic                wen,
    output logic                cupd,
    output logic                cnew,
    output logic                taken
);
    import bcu_pkg::*;

    logic mbit;

    always_comb begin
        mbit  = |(mem & mask);
        wdata = mem;
        wen   = 1'b0;
        cupd  = 1'b0;
        cnew  = carry;
        taken = 1'b0;
        unique case (op)
            OP_BITSC: begin
                wen   = 1'b1;
                wdata = pol_clear ? (mem & ~mask) : (mem | mask);
            end
            OP_BITBR: taken = (mbit != pol_clear);
            OP_COR:   begin cupd = 1'b1; cnew = carry | mbit;  end
            OP_CORN:  begin cupd = 1'b1; cnew = carry | ~mbit; end
            OP_CAND:  begin cupd = 1'b1; cnew = carry & mbit;  end
            OP_CANDN: begin cupd = 1'b1; cnew = carry & ~mbit; end
            OP_CXOR:  begin cupd = 1'b1; cnew = carry ^ mbit;  end
            OP_CLD:   begin cupd = 1'b1; cnew = mbit;          end
            OP_CST: begin
                wen   = 1'b1;
                wdata = (mem & ~mask) | (carry ? mask : '0);
            end
            OP_TGL: begin
                wen   = 1'b1;
                wdata = mem ^ mask;
            end
            OP_TSET: begin
                wen   = 1'b1;
                wdata = mem | acc;
            end
            OP_TCLR: begin
                wen   = 1'b1;
                wdata = mem & ~acc;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bcu_cmpflags.sv
module bcu_cmpflags #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] mem,
    output logic              zf,
    output logic              nf
);
    logic [DATA_W-1:0] diff;

    always_comb begin
        diff = acc - mem;
        zf   = (diff == '0);
        nf   = diff[DATA_W-1];
    end

endmodule

// File: rtl/bitcarry_unit.sv
module bitcarry_unit #(
    parameter int DATA_W = 8,
    parameter int OPC_W  = 8,
    parameter int OPER_W = 16,
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op_i,
    input  logic [OPC_W-1:0]  opc_i,
    input  logic [OPER_W-1:0] operand_i,
    input  logic [DATA_W-1:0] mem_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic              carry_i,
    output logic              out_valid,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] addr_o,
    output logic              carry_upd,
    output logic              carry_o,
    output logic              zn_upd,
    output logic              z_o,
    output logic              n_o,
    output logic              br_taken
);
    import bcu_pkg::*;

    typedef struct packed {
        logic              vld;
        logic              wen;
        logic [DATA_W-1:0] wdata;
        logic [ADDR_W-1:0] addr;
        logic              cupd;
        logic              cnew;
        logic              znupd;
        logic              z;
        logic              n;
        logic              br;
    } res_t;

    bcu_op_e           op;
    logic [DATA_W-1:0] mask;
    logic              pol_clear;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic              wen, cupd, cnew, taken;
    logic              zf, nf;
    logic              is_test;
    res_t              res_d, res_q;

    assign op = bcu_op_e'(op_i);

    bcu_decode #(
        .DATA_W(DATA_W), .OPC_W(OPC_W), .OPER_W(OPER_W), .ADDR_W(ADDR_W)
    ) u_decode (
        .op(op), .opc(opc_i), .operand(operand_i),
        .mask(mask), .pol_clear(pol_clear), .addr(addr)
    );

    bcu_bitops #(.DATA_W(DATA_W)) u_bitops (
        .op(op), .mem(mem_i), .acc(acc_i), .mask(mask),
        .pol_clear(pol_clear), .carry(carry_i),
        .wdata(wdata), .wen(wen), .cupd(cupd), .cnew(cnew), .taken(taken)
    );

    bcu_cmpflags #(.DATA_W(DATA_W)) u_cmp (
        .acc(acc_i), .mem(mem_i), .zf(zf), .nf(nf)
    );

    always_comb begin
        is_test = (op == OP_TSET) || (op == OP_TCLR);
        res_d   = '0;
        if (in_valid) begin
            res_d.vld   = 1'b1;
            res_d.wen   = wen;
            res_d.wdata = wdata;
            res_d.addr  = addr;
            res_d.cupd  = cupd;
            res_d.cnew  = cnew;
            res_d.znupd = is_test;
            res_d.z     = is_test & zf;
            res_d.n     = is_test & nf;
            res_d.br    = taken;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.vld;
    assign wr_en     = res_q.wen;
    assign wr_data   = res_q.wdata;
    assign addr_o    = res_q.addr;
    assign carry_upd = res_q.cupd;
    assign carry_o   = res_q.cnew;
    assign zn_upd    = res_q.znupd;
    assign z_o       = res_q.z;
    assign n_o       = res_q.n;
    assign br_taken  = res_q.br;

endmodule

// File: rtl/bitcarry_unit_chk.sv
module bitcarry_unit_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] mem_i,
    input logic [DATA_W-1:0] acc_i,
    input logic              carry_i,
    input logic              out_valid,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              carry_upd,
    input logic              carry_o,
    input logic              zn_upd,
    input logic              br_taken
);
    // R2: one-cycle latency of the valid flag
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: idle input gives quiet outputs next cycle
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wr_en && !carry_upd && !zn_upd && !br_taken));

    // R4: a branch decision never comes with a write or a flag strobe
    p_branch_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> (!wr_en && !carry_upd && !zn_upd));

    // R8: toggle changes exactly one bit of the byte
    p_toggle_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_i == 4'd10) |=> (wr_en && $countones(wr_data ^ $past(mem_i)) == 1));

    // R7: store-carry changes at most one bit
    p_store_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_i == 4'd9) |=> ($countones(wr_data ^ $past(mem_i)) <= 1 && !carry_upd));

    // R9: test-and-set leaves every accumulator bit set in memory
    p_tset_cover_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_i == 4'd11) |=> ((wr_data & $past(acc_i)) == $past(acc_i) && zn_upd && !carry_upd));

    // R10: carry passes through when not updated
    p_carry_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(op_i inside {[4'd3:4'd8]})) |=> (!carry_upd && carry_o == $past(carry_i)));

endmodule

bind bitcarry_unit bitcarry_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op_i),
    .mem_i(mem_i), .acc_i(acc_i), .carry_i(carry_i),
    .out_valid(out_valid), .wr_en(wr_en), .wr_data(wr_data),
    .carry_upd(carry_upd), .carry_o(carry_o), .zn_upd(zn_upd),
    .br_taken(br_taken)
);

// File: tb/tb_bitcarry_unit.sv
module tb_bitcarry_unit;

    localparam int RES_W = 29;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_i = '0;
    logic [7:0]  opc_i = '0;
    logic [15:0] operand_i = '0;
    logic [7:0]  mem_i = '0;
    logic [7:0]  acc_i = '0;
    logic        carry_i = 1'b0;
    logic        out_valid, wr_en, carry_upd, carry_o, zn_upd, z_o, n_o, br_taken;
    logic [7:0]  wr_data;
    logic [12:0] addr_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bitcarry_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op_i),
        .opc_i(opc_i), .operand_i(operand_i), .mem_i(mem_i), .acc_i(acc_i),
        .carry_i(carry_i), .out_valid(out_valid), .wr_en(wr_en),
        .wr_data(wr_data), .addr_o(addr_o), .carry_upd(carry_upd),
        .carry_o(carry_o), .zn_upd(zn_upd), .z_o(z_o), .n_o(n_o),
        .br_taken(br_taken)
    );

    function automatic logic [RES_W-1:0] outs();
        return {out_valid, wr_en, wr_data, addr_o, carry_upd, carry_o,
                zn_upd, z_o, n_o, br_taken};
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3, 4'd4, 4'd5, 4'd6, 4'd7: return "R6";
            4'd8, 4'd9: return "R7";
            4'd10: return "R8";
            4'd11, 4'd12: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Reference built from the requirement text
    function automatic logic [RES_W-1:0] model(input logic [3:0] op, input logic [7:0] opc,
        input logic [15:0] oper, input logic [7:0] mem, input logic [7:0] acc, input logic c);
        int    b;
        logic  mb, we, cu, cn, zu, z, n, br;
        logic [7:0] wd, diff;
        b  = (op == 4'd1 || op == 4'd2) ? int'(opc[7:5]) : int'(oper[15:13]); // R5
        mb = mem[b];
        wd = mem; we = 0; cu = 0; cn = c; zu = 0; z = 0; n = 0; br = 0;
        diff = acc - mem;
        case (op)
            4'd1:  begin we = 1; wd[b] = ~opc[4]; end
            4'd2:  br = opc[4] ? !mb : mb;
            4'd3:  begin cu = 1; cn = c | mb; end
            4'd4:  begin cu = 1; cn = c | !mb; end
            4'd5:  begin cu = 1; cn = c & mb; end
            4'd6:  begin cu = 1; cn = c & !mb; end
            4'd7:  begin cu = 1; cn = c ^ mb; end
            4'd8:  begin cu = 1; cn = mb; end
            4'd9:  begin we = 1; wd[b] = c; end
            4'd10: begin we = 1; wd[b] = !mb; end
            4'd11: begin we = 1; wd = mem | acc; zu = 1; z = (diff == 0); n = diff[7]; end
            4'd12: begin we = 1; wd = mem & ~acc; zu = 1; z = (diff == 0); n = diff[7]; end
            default: ;
        endcase
        return {1'b1, we, wd, oper[12:0], cu, cn, zu, z, n, br};
    endfunction

    task automatic check(input string req, input logic [RES_W-1:0] exp);
        checks++;
        if (outs() !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, outs(), exp);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge (one register)
    task automatic run_op(input logic [3:0] op, input logic [7:0] opc,
        input logic [15:0] oper, input logic [7:0] mem, input logic [7:0] acc, input logic c);
        in_valid = 1'b1; op_i = op; opc_i = opc; operand_i = oper;
        mem_i = mem; acc_i = acc; carry_i = c;
        @(negedge clk);
        check(req_of(op), model(op, opc, oper, mem, acc, c));
    endtask

    task automatic run_idle();
        in_valid = 1'b0;
        op_i = 4'd11; mem_i = 8'h5A; acc_i = 8'hFF; carry_i = 1'b1;
        @(negedge clk);
        check("R2", '0);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h1357);
        repeat (3) @(negedge clk);
        check("R1", '0);  // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", '0);  // R1 first cycle after reset, no op yet

        run_idle();       // R2

        // Sweep all used classes at every bit position (R3..R9, R5 via address)
        for (int op = 1; op <= 12; op++) begin
            for (int b = 0; b < 8; b++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [7:0]  opc, mem, acc;
                    logic [15:0] oper;
                    opc  = {3'(b), 1'($urandom), 4'($urandom)};
                    oper = {3'(b), 13'($urandom)};
                    mem  = 8'($urandom);
                    acc  = 8'($urandom);
                    run_op(4'(op), opc, oper, mem, acc, 1'($urandom));
                end
            end
        end

        // R9 corners: equal values, acc one above, acc one below memory
        run_op(4'd11, 8'h0E, 16'h1234, 8'h80, 8'h80, 1'b1);
        run_op(4'd12, 8'h4E, 16'h0001, 8'h3C, 8'h3D, 1'b0);
        run_op(4'd11, 8'h0E, 16'h1FFF, 8'h01, 8'h00, 1'b0);
        // R7 store: target bit matches carry, then opposite
        run_op(4'd9, 8'hCA, 16'hE000, 8'h80, 8'h00, 1'b1);
        run_op(4'd9, 8'hCA, 16'hE000, 8'h80, 8'h00, 1'b0);
        run_op(4'd9, 8'hCA, 16'h0000, 8'hFE, 8'h00, 1'b1);
        // R4 both polarities at bit 7 and bit 0
        run_op(4'd2, 8'hE3, 16'h0010, 8'h80, 8'h00, 1'b0);
        run_op(4'd2, 8'hF3, 16'h0010, 8'h80, 8'h00, 1'b0);
        run_op(4'd2, 8'h13, 16'h0010, 8'hFE, 8'h00, 1'b0);
        // R10 unused classes pass through quietly
        for (int op = 13; op <= 15; op++) begin
            run_op(4'(op), 8'hFF, 16'hFFFF, 8'hA5, 8'hFF, 1'b1);
        end
        run_op(4'd0, 8'h02, 16'h2000, 8'h00, 8'h01, 1'b0);
        run_idle();       // R2 after activity
        in_valid = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule